// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit with Condition Flags

This block is the shift and rotate stage of a processor execute path. A single combinational pass takes one data word, a shift amount and an operation code. It returns the shifted or rotated word, plus the negative, zero and carry flags that the shift produces. Five operations are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right that passes through the carry.

The amount has two sources. The first is an 8-bit register byte, used as is over the full range 0 to 255. The second is a short immediate field, whose meaning depends on the operation. The carry flag takes the last bit shifted out, and a zero amount leaves it alone. The flags change only when the flag-update input is high; otherwise the incoming flags pass straight through. There is no clock and no state, so the unit fits inside one pipeline stage.

Top module: `shf_unit`

## Requirements
- R1: Operation code 3'b000 is a logical left shift with zero fill. For an amount k from 1 to 32, the carry is operand bit 32-k. An amount of 32 gives a zero result with the carry equal to operand bit 0. Any amount above 32 gives zero with the carry cleared.
- R2: Operation code 3'b001 is a logical right shift with zero fill. For k from 1 to 32 the carry is operand bit k-1, so k=32 gives zero with carry equal to bit 31. Any amount above 32 gives zero with the carry cleared.
- R3: Operation code 3'b010 is an arithmetic right shift that fills with copies of bit 31. For an amount of 32 or more, every result bit equals bit 31, and so does the carry.
- R4: Operation code 3'b011 rotates right by the amount modulo 32. Each bit that leaves bit 0 re-enters at bit 31. For a nonzero amount the carry equals result bit 31, so a nonzero multiple of 32 returns the operand with the carry equal to its bit 31.
- R5: Operation code 3'b100 shifts right by exactly one bit and puts the incoming carry into bit 31. Its new carry is operand bit 0, and the amount inputs have no effect on it.
- R6: For codes 3'b000 to 3'b011, an effective amount of zero returns the operand unchanged and keeps the incoming carry.
- R7: When use_imm_i is 0, the amount is reg_amt_i, an 8-bit value from 0 to 255 used without any reduction.
- R8: When use_imm_i is 1, the amount is the 5-bit imm_amt_i. For codes 3'b001 and 3'b010, a field of 0 means 32. For codes 3'b000 and 3'b011, the field is taken as its own value, 0 to 31.
- R9: With upd_flags_i high, n_o equals result bit 31, z_o is 1 exactly when the result is all zeros, and c_o follows R1 to R6.
- R10: With upd_flags_i low, n_o, z_o and c_o equal n_i, z_i and c_i, while result_o is still computed.
- R11: Codes 3'b101 to 3'b111 return the operand unchanged, and the carry they produce is c_i.
- R12: The unit is purely combinational. Its outputs follow an input change within the same cycle, and no clock or reset is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Data word to shift or rotate |
| op_sel_i | input | 3 | Operation code (see R1 to R5, R11) |
| use_imm_i | input | 1 | 1 selects the immediate amount, 0 selects the register byte |
| reg_amt_i | input | 8 | Register-sourced shift amount |
| imm_amt_i | input | 5 | Immediate shift amount field |
| upd_flags_i | input | 1 | 1 lets the flags take the shift result |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| c_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted or rotated word |
| n_o | output | 1 | Outgoing negative flag |
| z_o | output | 1 | Outgoing zero flag |
| c_o | output | 1 | Outgoing carry flag |

## Verification
The bench builds the unit with its defaults: a 32-bit data word, an 8-bit register amount and the derived 5-bit immediate. The 8-bit amount reaches well beyond the word width, so the same build covers shifts of exactly 32, shifts of more than 32, and rotates by 64, 96 and up to 255. The 5-bit immediate reaches the field-0-means-32 case for the right shifts.

// File: rtl/shf_pkg.sv
// Package: shared operation codes for the shift unit.
// Assumes a 3-bit operation select; codes above SHF_RRX are unused.
package shf_pkg;
    localparam logic [2:0] SHF_LSL = 3'd0;
    localparam logic [2:0] SHF_LSR = 3'd1;
    localparam logic [2:0] SHF_ASR = 3'd2;
    localparam logic [2:0] SHF_ROR = 3'd3;
    localparam logic [2:0] SHF_RRX = 3'd4;
endpackage

// File: rtl/shf_amount_sel.sv
// Module: picks the effective shift amount from the register byte or the
// immediate field. Assumes AMT_W > IMM_W so that the value DATA_W fits.
module shf_amount_sel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = $clog2(DATA_W)
) (
    input  logic [2:0]       op_sel_i,
    input  logic             use_imm_i,
    input  logic [AMT_W-1:0] reg_amt_i,
    input  logic [IMM_W-1:0] imm_amt_i,
    output logic [AMT_W-1:0] eff_amt_o
);
    import shf_pkg::*;

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic [AMT_W-1:0] imm_ext;
    logic             right_kind;

    // Purpose: widen the immediate and apply the zero-means-full rule.
    always_comb begin
        imm_ext    = {{(AMT_W-IMM_W){1'b0}}, imm_amt_i};
        right_kind = (op_sel_i == SHF_LSR) || (op_sel_i == SHF_ASR);
        if (!use_imm_i)
            eff_amt_o = reg_amt_i;
        else if (right_kind && (imm_amt_i == '0))
            eff_amt_o = FULL_AMT;
        else
            eff_amt_o = imm_ext;
    end
endmodule

// File: rtl/shf_core.sv
// Module: barrel datapath. One staged right shifter over a
// {fill, source, guard} vector serves all four shift kinds: left shifts run
// on a bit-reversed source, and the guard bit catches the last bit out.
// Assumes DATA_W is a power of two (rotate uses the low IMM_W amount bits).
module shf_core #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = $clog2(DATA_W)
) (
    input  logic [2:0]        op_sel_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [AMT_W-1:0]  eff_amt_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    import shf_pkg::*;

    localparam int KW = IMM_W + 1;
    localparam int VW = 2 * DATA_W + 1;
    localparam logic [KW-1:0]    K_FULL   = KW'(DATA_W);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic [KW-1:0]     k_amt;
    logic [DATA_W-1:0] src_word;
    logic [DATA_W-1:0] fill_word;
    logic [DATA_W-1:0] rev_operand;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] rev_shifted;
    logic              guard_bit;
    logic              amt_zero;
    logic              amt_over;
    logic              amt_full;
    logic [VW-1:0]     stage [0:KW];

    // Purpose: bit-reverse the operand for left shifts.
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            rev_operand[i] = operand_i[DATA_W-1-i];
    end

    // Purpose: classify the amount and clamp it to the stage range.
    always_comb begin
        amt_zero = (eff_amt_i == '0);
        amt_over = (eff_amt_i > FULL_AMT);
        amt_full = (eff_amt_i >= FULL_AMT);
        if (op_sel_i == SHF_ROR)
            k_amt = {1'b0, eff_amt_i[IMM_W-1:0]};
        else if (amt_full)
            k_amt = K_FULL;
        else
            k_amt = eff_amt_i[KW-1:0];
    end

    // Purpose: choose the source word and the fill entering from the top.
    always_comb begin
        src_word = (op_sel_i == SHF_LSL) ? rev_operand : operand_i;
        case (op_sel_i)
            SHF_ASR: fill_word = {DATA_W{operand_i[DATA_W-1]}};
            SHF_ROR: fill_word = operand_i;
            default: fill_word = '0;
        endcase
    end

    assign stage[0] = {fill_word, src_word, 1'b0};

    genvar s;
    generate
        for (s = 0; s < KW; s++) begin : g_stage
            // Purpose: shift right by 2**s when amount bit s is set.
            always_comb begin
                if (k_amt[s])
                    stage[s+1] = stage[s] >> (1 << s);
                else
                    stage[s+1] = stage[s];
            end
        end
    endgenerate

    // Purpose: split the final stage and undo the reversal for left shifts.
    always_comb begin
        shifted   = stage[KW][DATA_W:1];
        guard_bit = stage[KW][0];
        for (int i = 0; i < DATA_W; i++)
            rev_shifted[i] = shifted[DATA_W-1-i];
    end

    // Purpose: select result and carry per operation.
    always_comb begin
        case (op_sel_i)
            SHF_LSL: begin
                result_o = amt_over ? '0 : rev_shifted;
                carry_o  = amt_zero ? c_i : (amt_over ? 1'b0 : guard_bit);
            end
            SHF_LSR: begin
                result_o = amt_over ? '0 : shifted;
                carry_o  = amt_zero ? c_i : (amt_over ? 1'b0 : guard_bit);
            end
            SHF_ASR: begin
                result_o = shifted;
                carry_o  = amt_zero ? c_i : guard_bit;
            end
            SHF_ROR: begin
                result_o = shifted;
                carry_o  = amt_zero ? c_i : shifted[DATA_W-1];
            end
            SHF_RRX: begin
                result_o = {c_i, operand_i[DATA_W-1:1]};
                carry_o  = operand_i[0];
            end
            default: begin
                result_o = operand_i;
                carry_o  = c_i;
            end
        endcase
    end
endmodule

// File: rtl/shf_flags.sv
// Module: forms the outgoing N, Z and C flags. Assumes the carry candidate
// already follows the shift rules; this stage only gates by the update enable.
module shf_flags #(
    parameter int DATA_W = 32
) (
    input  logic              upd_flags_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              shift_c_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              c_i,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o
);
    // Purpose: update flags from the result or pass the old ones through.
    always_comb begin
        if (upd_flags_i) begin
            n_o = result_i[DATA_W-1];
            z_o = (result_i == '0);
            c_o = shift_c_i;
        end else begin
            n_o = n_i;
            z_o = z_i;
            c_o = c_i;
        end
    end
endmodule

// File: rtl/shf_unit.sv
// Module: top of the combinational shift and rotate unit with flags.
// Assumes DATA_W is a power of two and AMT_W > $clog2(DATA_W).
module shf_unit #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [2:0]        op_sel_i,
    input  logic              use_imm_i,
    input  logic [AMT_W-1:0]  reg_amt_i,
    input  logic [IMM_W-1:0]  imm_amt_i,
    input  logic              upd_flags_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] result_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o
);
    import shf_pkg::*;

    logic [AMT_W-1:0] eff_amt;
    logic             shift_c;

    shf_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_amt (
        .op_sel_i  (op_sel_i),
        .use_imm_i (use_imm_i),
        .reg_amt_i (reg_amt_i),
        .imm_amt_i (imm_amt_i),
        .eff_amt_o (eff_amt)
    );

    shf_core #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_core (
        .op_sel_i  (op_sel_i),
        .operand_i (operand_i),
        .eff_amt_i (eff_amt),
        .c_i       (c_i),
        .result_o  (result_o),
        .carry_o   (shift_c)
    );

    shf_flags #(.DATA_W(DATA_W)) u_flags (
        .upd_flags_i (upd_flags_i),
        .result_i    (result_o),
        .shift_c_i   (shift_c),
        .n_i         (n_i),
        .z_i         (z_i),
        .c_i         (c_i),
        .n_o         (n_o),
        .z_o         (z_o),
        .c_o         (c_o)
    );

    // Purpose: cross-check port behaviour across the three sub-blocks.
    always_comb begin
        if (!$isunknown({operand_i, op_sel_i, eff_amt, upd_flags_i, n_i, z_i, c_i})) begin
            if (op_sel_i < SHF_RRX && eff_amt == '0)
                assert_zero_amt_R6: assert (result_o == operand_i && shift_c == c_i);
            if (op_sel_i == SHF_ASR)
                assert_asr_sign_R3: assert (result_o[DATA_W-1] == operand_i[DATA_W-1]);
            if (op_sel_i == SHF_LSL && eff_amt != '0)
                assert_lsl_low_R1: assert (result_o[0] == 1'b0);
            if (op_sel_i == SHF_RRX)
                assert_rrx_top_R5: assert (result_o[DATA_W-1] == c_i && shift_c == operand_i[0]);
            if (!upd_flags_i)
                assert_flag_hold_R10: assert (n_o == n_i && z_o == z_i && c_o == c_i);
            if (upd_flags_i)
                assert_z_match_R9: assert (z_o == (result_o == '0));
        end
    end
endmodule

// File: tb/shf_unit_bench.sv
module shf_unit_bench;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic [W-1:0]  operand = '0;
    logic [2:0]    op_sel = 3'd0;
    logic          use_imm = 1'b0;
    logic [7:0]    reg_amt = '0;
    logic [4:0]    imm_amt = '0;
    logic          upd = 1'b0;
    logic          n_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
    logic [W-1:0]  result;
    logic          n_out, z_out, c_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    shf_unit u_shf_unit (
        .operand_i(operand), .op_sel_i(op_sel), .use_imm_i(use_imm),
        .reg_amt_i(reg_amt), .imm_amt_i(imm_amt), .upd_flags_i(upd),
        .n_i(n_in), .z_i(z_in), .c_i(c_in),
        .result_o(result), .n_o(n_out), .z_o(z_out), .c_o(c_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int eff_amount(input logic [2:0] op, input logic ui,
                                      input logic [7:0] ra, input logic [4:0] ia);
        if (!ui) return int'(ra);
        if ((op == 3'd1 || op == 3'd2) && ia == 5'd0) return 32;
        return int'(ia);
    endfunction

    // Reference: step one bit at a time, tracking the bit that leaves.
    function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] x,
                                         input int amt, input logic cin);
        logic [W-1:0] v = x;
        logic c = cin;
        if (op == 3'd4) return {cin, x[W-1:1], x[0]};
        if (op > 3'd4) return {x, cin};
        for (int i = 0; i < amt; i++) begin
            case (op)
                3'd0: begin c = v[W-1]; v = {v[W-2:0], 1'b0}; end
                3'd1: begin c = v[0];   v = {1'b0, v[W-1:1]}; end
                3'd2: begin c = v[0];   v = {v[W-1], v[W-1:1]}; end
                default: begin c = v[0]; v = {v[0], v[W-1:1]}; end
            endcase
        end
        return {v, c};
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic run(input logic [2:0] op, input logic [W-1:0] x, input logic ui,
                       input logic [7:0] ra, input logic [4:0] ia, input logic up,
                       input logic ni, input logic zi, input logic ci, input string tag);
        logic [W:0] m;
        logic [W-1:0] er;
        logic en, ez, ec;
        @(negedge clk);
        op_sel = op; operand = x; use_imm = ui; reg_amt = ra; imm_amt = ia;
        upd = up; n_in = ni; z_in = zi; c_in = ci;
        #1;
        m  = model(op, x, eff_amount(op, ui, ra, ia), ci);
        er = m[W:1];
        en = up ? er[W-1] : ni;
        ez = up ? (er == '0) : zi;
        ec = up ? m[0] : ci;
        n_checks++;
        if (result !== er || n_out !== en || z_out !== ez || c_out !== ec) begin
            n_fail++;
            $display("FAIL %s: op=%0d x=%h ui=%0b ra=%0d ia=%0d act res=%h nzc=%b%b%b exp res=%h nzc=%b%b%b",
                     tag, op, x, ui, ra, ia, result, n_out, z_out, c_out, er, en, ez, ec);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        // Idle state with all-zero inputs (R12: settles with no clock edge needed)
        run(3'd0, '0, 1'b0, 8'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        // R1 left shift corners
        run(3'd0, 32'h8000_0001, 1'b0, 8'd1,  5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        run(3'd0, 32'h0000_0001, 1'b0, 8'd32, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        run(3'd0, 32'hFFFF_FFFF, 1'b0, 8'd33, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        // R2 logical right corners
        run(3'd1, 32'h8000_0000, 1'b0, 8'd32, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        run(3'd1, 32'hFFFF_FFFF, 1'b0, 8'd200, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        // R3 arithmetic right
        run(3'd2, 32'h8000_0000, 1'b0, 8'd255, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        run(3'd2, 32'h7FFF_FFFF, 1'b0, 8'd40,  5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        // R4 rotate by multiples of 32
        run(3'd3, 32'h8765_4321, 1'b0, 8'd32, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        run(3'd3, 32'h1234_5678, 1'b0, 8'd64, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        run(3'd3, 32'h0000_0001, 1'b0, 8'd33, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        // R5 rotate through carry, amount ignored
        run(3'd4, 32'h0000_0003, 1'b0, 8'd77, 5'd9, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        run(3'd4, 32'h0000_0000, 1'b1, 8'd0,  5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        // R6 zero amount keeps operand and carry
        run(3'd0, 32'hDEAD_BEEF, 1'b0, 8'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        run(3'd3, 32'hDEAD_BEEF, 1'b1, 8'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        // R7 register byte used in full
        run(3'd1, 32'hF000_0000, 1'b0, 8'd31, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        // R8 immediate field zero means 32 for right shifts only
        run(3'd1, 32'h8000_0000, 1'b1, 8'd3, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        run(3'd2, 32'h8000_0000, 1'b1, 8'd3, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        run(3'd0, 32'h8000_0000, 1'b1, 8'd3, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        run(3'd0, 32'h0000_0003, 1'b1, 8'd0, 5'd31, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        // R9 N and Z
        run(3'd0, 32'h4000_0000, 1'b0, 8'd1, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        run(3'd1, 32'h0000_0001, 1'b0, 8'd1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        // R10 flags pass through when update is off
        run(3'd1, 32'h0000_0001, 1'b0, 8'd1, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        run(3'd2, 32'h8000_0000, 1'b0, 8'd4, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        // R11 unused codes
        run(3'd5, 32'hCAFE_0001, 1'b0, 8'd5, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        run(3'd7, 32'h0000_0000, 1'b1, 8'd5, 5'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            logic [W-1:0] x;
            logic [7:0] ra;
            op = 3'($urandom_range(0, 7));
            x  = $urandom;
            if (i % 4 == 0) x = (i % 8 == 0) ? '0 : {W{1'b1}};
            ra = (i % 3 == 0) ? 8'($urandom_range(28, 36)) : 8'($urandom);
            run(op, x, 1'($urandom), ra, 5'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), op_tag(op));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule